// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the host-facing register front end for a single PS/2 keyboard or mouse port. It sits on a simple 32-bit word-addressed peripheral bus that has separate read and write strobes. It holds a control word, a clock-divisor word and the most recently consumed receive byte. It also reports line and transfer status, presents an interrupt identification word, and serves a fixed read-only bank of eight identification bytes in the top words of a 4 KB window.

Received bytes come from a PS/2 receiver over a valid/ready byte interface. Only one byte is held at a time: the port stops accepting bytes while one is pending, which pushes back on the receiver. When the host writes the data word, the low byte goes out to a PS/2 transmitter as a one-cycle valid pulse. A single level interrupt output combines a gated receive-pending condition with a force bit in the control word.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset the control word, divisor word, last byte and pending flag are zero, `irq` is low, `rxReady` is high, `txValid` is low and `busRdata` is zero.
- R2: The word index is `busAddr[11:2]`. Word 0 (control) and word 3 (clock divisor) store all 32 written bits and read them back unchanged. The divisor has no other effect.
- R3: Word 1 (status) reads as bit 6 = not `txBusy`, bit 5 = `txBusy`, bit 4 = pending, bit 3 = `rxBusy`, bit 2 = parity, bit 1 = `lineClk`, bit 0 = `lineData`, with all other bits zero.
- R4: Status bit 2 is 1 exactly when the last latched byte contains an odd number of ones.
- R5: `rxReady` is high exactly when no byte is pending. A byte offered with `rxValid` while `rxReady` is high is held and sets pending. A byte offered while pending is ignored and does not replace the held byte.
- R6: A read of word 2 (data) while pending returns the held byte, copies it into the last-byte register and clears pending. Without pending, the read returns the last byte and changes nothing.
- R7: `irq` equals (pending AND control bit 4) OR control bit 3. It follows any control write or pending change on the cycle after the register update.
- R8: Word 4 (interrupt identification) reads as {30 zero bits, 1, pending}.
- R9: A write to word 2 raises `txValid` for exactly the following cycle, with `txByte` equal to bits [7:0] of the written value.
- R10: Reads of byte addresses 0xFE0 to 0xFFC return, in order of address, 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R11: Reads of any other address return zero. Writes to status, interrupt identification, the identification bank or unmapped addresses change no readable state and produce no `txValid`.
- R12: Read data appears on `busRdata` in the cycle after `busRd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the 4 KB window |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rxValid | input | 1 | Receiver offers a byte |
| rxByte | input | 8 | Offered receive byte |
| rxReady | output | 1 | Port can take a byte |
| rxBusy | input | 1 | Receiver is mid-frame |
| txValid | output | 1 | Transmit byte pulse |
| txByte | output | 8 | Transmit byte |
| txBusy | input | 1 | Transmitter is mid-frame |
| lineClk | input | 1 | Sampled PS/2 clock line |
| lineData | input | 1 | Sampled PS/2 data line |
| irq | output | 1 | Level interrupt |

## Verification
A host read of the data word can land in the same cycle in which the receiver offers a byte. With nothing pending, the read must return the old last byte while the offered byte is taken and pending rises. With a byte pending, the read pops it while the new offer is refused. Control writes can also meet a pending change in the same cycle, so the interrupt must reflect both. The bench provokes these collisions on purpose and also lets random traffic mix bus operations with receive offers in a single cycle. Every cycle is judged against a bench model that updates pending, the held byte and the control word in the order the requirements define.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;

  localparam int CTRL_FORCE_BIT = 3;
  localparam int CTRL_RXIE_BIT  = 4;

  localparam logic [9:0] WORD_CTRL = 10'd0;
  localparam logic [9:0] WORD_STAT = 10'd1;
  localparam logic [9:0] WORD_DATA = 10'd2;
  localparam logic [9:0] WORD_DIV  = 10'd3;
  localparam logic [9:0] WORD_IID  = 10'd4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_DATA,
    SEL_DIV,
    SEL_IID,
    SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrDiv;
    logic   wrData;
    logic   rdEn;
    rdSel_e sel;
    logic [2:0] idIdx;
  } regStrobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h50;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2_port_ctrl.sv
module ps2_port_ctrl
  import ps2_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output regStrobe_t        stb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedAddrBits;
  logic              inIdBank;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = busAddr[1:0];
  // The identification bank fills the top eight words of the window.
  assign inIdBank       = &wordIdx[WORD_W-1:3];

  always_comb begin
    stb        = '0;
    stb.sel    = SEL_NONE;
    stb.idIdx  = wordIdx[2:0];
    stb.rdEn   = busRd;
    if (busWr) begin
      stb.wrCtrl = (wordIdx == WORD_W'(WORD_CTRL));
      stb.wrDiv  = (wordIdx == WORD_W'(WORD_DIV));
      stb.wrData = (wordIdx == WORD_W'(WORD_DATA));
    end
    if (inIdBank) begin
      stb.sel = SEL_ID;
    end else begin
      case (wordIdx)
        WORD_W'(WORD_CTRL): stb.sel = SEL_CTRL;
        WORD_W'(WORD_STAT): stb.sel = SEL_STAT;
        WORD_W'(WORD_DATA): stb.sel = SEL_DATA;
        WORD_W'(WORD_DIV):  stb.sel = SEL_DIV;
        WORD_W'(WORD_IID):  stb.sel = SEL_IID;
        default:            stb.sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ps2_port_dp.sv
module ps2_port_dp
  import ps2_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic              rxBusy,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txBusy,
  input  logic              lineClk,
  input  logic              lineData,
  output logic              irq
);
  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] divReg;
  logic [7:0]        lastReg;
  logic [7:0]        holdReg;
  logic              pending;
  logic [DATA_W-1:0] rdataReg;
  logic              txValidReg;
  logic [7:0]        txByteReg;
  logic [DATA_W-1:0] rdNext;
  logic              popRx;
  logic              takeRx;
  logic [6:0]        statBits;

  assign rxReady = ~pending;
  assign popRx   = stb.rdEn && (stb.sel == SEL_DATA) && pending;
  assign takeRx  = rxValid && ~pending;

  assign statBits = {~txBusy, txBusy, pending, rxBusy, ^lastReg, lineClk, lineData};

  always_comb begin
    case (stb.sel)
      SEL_CTRL: rdNext = ctrlReg;
      SEL_STAT: rdNext = {{(DATA_W-7){1'b0}}, statBits};
      SEL_DATA: rdNext = {{PAD_W{1'b0}}, (pending ? holdReg : lastReg)};
      SEL_DIV:  rdNext = divReg;
      SEL_IID:  rdNext = {{(DATA_W-2){1'b0}}, 1'b1, pending};
      SEL_ID:   rdNext = {{PAD_W{1'b0}}, idByte(stb.idIdx)};
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      divReg     <= '0;
      lastReg    <= '0;
      holdReg    <= '0;
      pending    <= 1'b0;
      rdataReg   <= '0;
      txValidReg <= 1'b0;
      txByteReg  <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= busWdata;
      if (stb.wrDiv)  divReg  <= busWdata;
      txValidReg <= stb.wrData;
      if (stb.wrData) txByteReg <= busWdata[7:0];
      if (popRx) begin
        lastReg <= holdReg;
        pending <= 1'b0;
      end else if (takeRx) begin
        holdReg <= rxByte;
        pending <= 1'b1;
      end
      if (stb.rdEn) rdataReg <= rdNext;
    end
  end

  assign busRdata = rdataReg;
  assign txValid  = txValidReg;
  assign txByte   = txByteReg;
  assign irq      = (pending & ctrlReg[CTRL_RXIE_BIT]) | ctrlReg[CTRL_FORCE_BIT];

  // R5: a held byte is never overwritten by a new offer
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    pending && !popRx |=> $stable(holdReg));

  // R5: pending only rises after an offer from the receiver
  a_r5_rise_needs_offer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(rxValid));

  // R6: a pop moves the held byte into the last-byte register
  a_r6_pop_moves_byte: assert property (@(posedge clk) disable iff (!rstN)
    popRx |=> !pending && (lastReg == $past(holdReg)));

  // R12: read data holds while no read is issued
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdataReg));

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic              rxBusy,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txBusy,
  input  logic              lineClk,
  input  logic              lineData,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] ID_FIRST = ADDR_W'((1 << ADDR_W) - 32);

  regStrobe_t stb;

  ps2_port_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  ps2_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .rxReady  (rxReady),
    .rxBusy   (rxBusy),
    .txValid  (txValid),
    .txByte   (txByte),
    .txBusy   (txBusy),
    .lineClk  (lineClk),
    .lineData (lineData),
    .irq      (irq)
  );

  // R7: setting the force bit raises the interrupt on the next cycle
  a_r7_force_irq: assert property (@(posedge clk) disable iff (!rstN)
    busWr && (busAddr[ADDR_W-1:2] == WORD_W'(WORD_CTRL)) && busWdata[CTRL_FORCE_BIT] |=> irq);

  // R9: a data write emits its low byte on the next cycle
  a_r9_tx_forward: assert property (@(posedge clk) disable iff (!rstN)
    busWr && (busAddr[ADDR_W-1:2] == WORD_W'(WORD_DATA)) |=> txValid && (txByte == $past(busWdata[7:0])));

  // R10: first identification word
  a_r10_id_first: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (busAddr == ID_FIRST) |=> busRdata == DATA_W'(8'h50));

  // R11: the word after interrupt identification is unmapped
  a_r11_undef_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRd && (busAddr[ADDR_W-1:2] == WORD_W'(5)) |=> busRdata == '0);

endmodule

// File: tb/tb_ps2_port_regs.sv
`timescale 1ns/1ps
module tb_ps2_port_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady;
  logic        rxBusy = 1'b0;
  logic        txValid;
  logic [7:0]  txByte;
  logic        txBusy = 1'b0;
  logic        lineClk = 1'b0;
  logic        lineData = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mCtrl, mDiv;
  logic [7:0]  mLast, mHold;
  logic        mPend;

  always #2 clk = ~clk;

  ps2_port_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxValid(rxValid), .rxByte(rxByte),
    .rxReady(rxReady), .rxBusy(rxBusy), .txValid(txValid), .txByte(txByte),
    .txBusy(txBusy), .lineClk(lineClk), .lineData(lineData), .irq(irq)
  );

  function automatic logic oddOnes(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) if (b[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [7:0] idExp(input int i);
    case (i)
      0: return 8'h50; 1: return 8'h10; 2: return 8'h04; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    if (a >= 12'hFE0) return {24'b0, idExp(int'(a[4:2]))};
    case (a[11:2])
      10'd0: return mCtrl;
      10'd1: return {25'b0, ~txBusy, txBusy, mPend, rxBusy, oddOnes(mLast), lineClk, lineData};
      10'd2: return {24'b0, (mPend ? mHold : mLast)};
      10'd3: return mDiv;
      10'd4: return {30'b0, 1'b1, mPend};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle, entered and left at a falling edge.
  task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                      input logic [31:0] d, input logic rv, input logic [7:0] rb,
                      input string req);
    logic [31:0] expR;
    logic        accept;
    busWr = wr; busRd = rd; busAddr = a; busWdata = d; rxValid = rv; rxByte = rb;
    #0.5;
    check("R5 rxReady", {31'b0, rxReady}, {31'b0, ~mPend});
    expR   = expRead(a);
    accept = rv && !mPend;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0; rxValid = 1'b0;
    if (rd && a[11:2] == 10'd2 && mPend) begin mLast = mHold; mPend = 1'b0; end
    if (accept) begin mHold = rb; mPend = 1'b1; end
    if (wr && a[11:2] == 10'd0) mCtrl = d;
    if (wr && a[11:2] == 10'd3) mDiv = d;
    if (rd) check(req, busRdata, expR);
    check("R9 txValid", {31'b0, txValid}, {31'b0, (wr && a[11:2] == 10'd2)});
    if (wr && a[11:2] == 10'd2) check("R9 txByte", {24'b0, txByte}, {24'b0, d[7:0]});
    check("R7 irq", {31'b0, irq}, {31'b0, (mPend & mCtrl[4]) | mCtrl[3]});
  endtask

  task automatic rdW(input logic [11:0] a, input string req);
    step(1'b0, 1'b1, a, 32'b0, 1'b0, 8'b0, req);
  endtask

  task automatic wrW(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, a, d, 1'b0, 8'b0, "R2 write");
  endtask

  task automatic offer(input logic [7:0] b);
    step(1'b0, 1'b0, 12'h000, 32'b0, 1'b1, b, "R5 offer");
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [14];
    logic [31:0] held;
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h100,
              12'hFE0, 12'hFE4, 12'hFEC, 12'hFF4, 12'hFFC, 12'h008, 12'h004};
    void'($urandom(32'd20240611));
    mCtrl = '0; mDiv = '0; mLast = '0; mHold = '0; mPend = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 rxReady", {31'b0, rxReady}, 32'd1);
    check("R1 txValid", {31'b0, txValid}, 32'd0);
    check("R1 rdata", busRdata, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    rdW(12'h000, "R1 control");
    rdW(12'h00C, "R1 divisor");
    rdW(12'h008, "R1 last byte");
    rdW(12'h004, "R1 status");

    // R2: control and divisor hold all bits
    wrW(12'h000, 32'hA5A5_0060);
    rdW(12'h000, "R2 control");
    wrW(12'h00C, 32'hDEAD_BEEF);
    rdW(12'h00C, "R2 divisor");

    // R3: status line and busy inputs
    txBusy = 1'b1; rxBusy = 1'b1; lineClk = 1'b1; lineData = 1'b0;
    rdW(12'h004, "R3 status inputs");
    txBusy = 1'b0; rxBusy = 1'b0; lineData = 1'b1;
    rdW(12'h004, "R3 status inputs");

    // R4: parity of odd and even bytes
    offer(8'h01); rdW(12'h008, "R6 pop"); rdW(12'h004, "R4 odd parity");
    offer(8'h03); rdW(12'h008, "R6 pop"); rdW(12'h004, "R4 even parity");

    // R5: second offer while pending is ignored
    offer(8'h7E); offer(8'h11);
    rdW(12'h004, "R3 rx full");
    rdW(12'h010, "R8 iid pending");
    rdW(12'h008, "R5 held byte kept");
    // R6: read with nothing pending returns last unchanged
    rdW(12'h008, "R6 no pending");
    rdW(12'h010, "R8 iid idle");

    // R7: gating and force
    wrW(12'h000, 32'h10);
    offer(8'h22);
    rdW(12'h008, "R7 pop clears irq");
    wrW(12'h000, 32'h08);
    wrW(12'h000, 32'h00);
    // collision: control write and offer in the same cycle
    step(1'b1, 1'b0, 12'h000, 32'h10, 1'b1, 8'h33, "R7 collision");
    // collision: data read with nothing pending and offer in the same cycle
    rdW(12'h008, "R6 drain");
    step(1'b0, 1'b1, 12'h008, 32'b0, 1'b1, 8'h44, "R6 read with offer");
    rdW(12'h008, "R6 collided byte");

    // R9: data write forwards low byte
    wrW(12'h008, 32'h1234_56C3);
    // R10: identification bank
    for (int i = 0; i < 8; i++) rdW(12'hFE0 + 12'(i * 4), "R10 id byte");
    // R11: unmapped reads and ignored writes
    rdW(12'h014, "R11 unmapped");
    rdW(12'h800, "R11 unmapped");
    wrW(12'h004, 32'hFFFF_FFFF);
    wrW(12'h010, 32'hFFFF_FFFF);
    wrW(12'hFE0, 32'hFFFF_FFFF);
    wrW(12'h014, 32'hFFFF_FFFF);
    rdW(12'h004, "R11 status after write");
    rdW(12'h010, "R11 iid after write");
    rdW(12'hFE0, "R11 id after write");
    rdW(12'h000, "R11 control after write");
    // R12: read data holds with no read
    rdW(12'h00C, "R12 read");
    held = busRdata;
    step(1'b0, 1'b0, 12'h000, 32'b0, 1'b0, 8'b0, "R12 idle");
    check("R12 hold", busRdata, held);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [11:0] a;
      op = int'($urandom % 4);
      a  = addrs[$urandom % 14];
      txBusy = 1'($urandom); rxBusy = 1'($urandom);
      lineClk = 1'($urandom); lineData = 1'($urandom);
      step(op == 0, op == 1, a, $urandom, ($urandom % 3) == 0, 8'($urandom), "R6 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule